// File: doc/BRIEF.md
# Two-Byte Serial-Bus FIFO Controller

This block buffers bytes between a host register port and the byte-shift engine of a two-wire serial bus controller. It keeps one FIFO for each direction, each holding at most two bytes. The host writes bytes to be sent and reads bytes that have arrived. The shift engine takes bytes to send and puts received bytes through a simple handshake. The bus protocol itself sits outside this block.

A five-bit control register sets the behaviour of the block. Each direction has a level-sensitive purge that stays in force until software clears it. Each direction also has an interrupt threshold, which raises the request either per byte or per pair of bytes. One further bit decides whether host accesses stall or complete at once. Both FIFOs report their fill as a 2-bit code. The block drives level interrupt requests for each direction and a sticky overflow flag for dropped transmit writes.

Top module: `pbf_ctl`

## Requirements
- R1: After reset, both levels read 00, tx_irq is 1, rx_irq is 0, tx_overflow is 0, tx_byte_avail is 0, rx_byte_block is 0, and the control register reads 0.
- R2: Each level encodes the bytes held: 0 bytes gives 00, 1 byte gives 01, 2 bytes gives 11. The code 10 never appears.
- R3: Bytes leave each FIFO in the order they entered. A push and a pop on the same FIFO in one cycle leave its level unchanged.
- R4: The host address map is: 0 is the control register (read and write), 1 is transmit data (write), 2 is receive data (read). Control bits: [0] no_stall, [1] tx_pair, [2] rx_pair, [3] tx_purge, [4] rx_purge. Control accesses always complete at once.
- R5: While tx_purge is 1, the transmit FIFO is emptied, tx_level reads 00, tx_byte_avail is 0, tx_irq is 0, and host writes to address 1 complete but are discarded. Bytes held before the purge do not return once it is cleared.
- R6: While rx_purge is 1, the receive FIFO is emptied, rx_level reads 00, rx_irq is 0, and rx_byte_block is 1, so no byte is accepted from the shift engine.
- R7: With tx_pair 0, tx_irq is 1 when tx_level is 00 or 01. With tx_pair 1, tx_irq is 1 only when tx_level is 00.
- R8: With rx_pair 0, rx_irq is 1 when rx_level is 01 or 11. With rx_pair 1, rx_irq is 1 only when rx_level is 11.
- R9: With no_stall 0, a read of address 2 holds host_ready low while no byte is available, and a write to address 1 holds host_ready low while both slots are taken. A stalled access changes no state. host_ready is high in the cycle an access completes.
- R10: With no_stall 1, every access completes at once. A read of an empty receive FIFO returns 0x00 and leaves rx_level unchanged. A write to a full transmit FIFO is dropped and sets tx_overflow. tx_overflow stays set until tx_purge is 1 for one cycle.
- R11: A tx_byte_take while tx_byte_avail is 1 pops the head byte shown on tx_byte. An rx_byte_put while rx_byte_block is 0 stores rx_byte. A put while rx_byte_block is 1 (both slots taken) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Host access request, held until ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while host_ready is high |
| host_ready | output | 1 | Access completes in this cycle |
| tx_byte_avail | output | 1 | A transmit byte is available to the shift engine |
| tx_byte | output | DATA_W | Head transmit byte |
| tx_byte_take | input | 1 | Shift engine takes the head byte |
| rx_byte_put | input | 1 | Shift engine offers a received byte |
| rx_byte | input | DATA_W | Received byte |
| rx_byte_block | output | 1 | Receive side refuses bytes |
| tx_level | output | 2 | Transmit fill code |
| rx_level | output | 2 | Receive fill code |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
A wrong fill count appears at the level outputs and at the interrupt lines on the clock edge after the push or pop that caused it. A wrong read pointer appears as a byte out of order at the next pop, one access later. A stale purge or threshold bit shows up within one cycle as a level, block or interrupt value that disagrees with the control readback. A wrong stall decision appears at once on host_ready. The bench also checks that a stalled or dropped byte never appears at a later pop.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

    // control register layout, MSB first
    typedef struct packed {
        logic rx_purge;
        logic tx_purge;
        logic rx_pair;
        logic tx_pair;
        logic no_stall;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_TXD = 2'd1;
    localparam logic [1:0] ADDR_RXD = 2'd2;

endpackage

// File: rtl/pbf_fifo.sv
module pbf_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (clear) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = bump(st_q.wr);
            end
            if (do_pop) begin
                st_d.rd = bump(st_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_data = st_q.mem[st_q.rd];
    assign count    = st_q.cnt;

endmodule

// File: rtl/pbf_stat.sv
module pbf_stat #(
    parameter bit IS_TX = 1'b0,
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] count,
    input  logic             purge,
    input  logic             pair,
    output logic [1:0]       level,
    output logic             irq
);

    logic none_held, both_held, raw_irq;

    assign none_held = (count == '0);
    assign both_held = (count == CNT_W'(2));
    assign level     = purge ? 2'b00 : {both_held, !none_held};

    generate
        if (IS_TX) begin : g_tx
            // free slots drive the request
            assign raw_irq = pair ? none_held : !both_held;
        end else begin : g_rx
            // held bytes drive the request
            assign raw_irq = pair ? both_held : !none_held;
        end
    endgenerate

    assign irq = raw_irq && !purge;

endmodule

// File: rtl/pbf_ctl.sv
module pbf_ctl
    import pbf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              tx_byte_avail,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_byte_take,
    input  logic              rx_byte_put,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_byte_block,
    output logic [1:0]        tx_level,
    output logic [1:0]        rx_level,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              tx_overflow
);

    localparam int DEPTH = 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ctl_t ctl;
        logic ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] rx_head;
    logic              wr_ctl, wr_tx, rd_rx, rd_ctl;
    logic              tx_room, rx_has;
    logic              tx_push, rx_pop, ovf_evt;
    logic [CTL_W-1:0]  ctl_bits;

    assign ctl_bits = st_q.ctl;

    assign wr_ctl = host_req && host_we && (host_addr == ADDR_CTL);
    assign rd_ctl = host_req && !host_we && (host_addr == ADDR_CTL);
    assign wr_tx  = host_req && host_we && (host_addr == ADDR_TXD);
    assign rd_rx  = host_req && !host_we && (host_addr == ADDR_RXD);

    // a purging transmit side swallows writes, so it always has room
    assign tx_room = st_q.ctl.tx_purge || (tx_cnt != CNT_W'(DEPTH));
    assign rx_has  = !st_q.ctl.rx_purge && (rx_cnt != '0);

    always_comb begin
        host_ready = 1'b1;
        host_rdata = '0;
        if (wr_tx) begin
            host_ready = tx_room || st_q.ctl.no_stall;
        end else if (rd_rx) begin
            host_ready = rx_has || st_q.ctl.no_stall;
            host_rdata = rx_has ? rx_head : '0;
        end else if (rd_ctl) begin
            host_rdata = DATA_W'(ctl_bits);
        end
    end

    assign tx_push = wr_tx && !st_q.ctl.tx_purge && (tx_cnt != CNT_W'(DEPTH));
    assign ovf_evt = wr_tx && st_q.ctl.no_stall && !tx_room;
    assign rx_pop  = rd_rx && rx_has;

    assign tx_byte_avail = !st_q.ctl.tx_purge && (tx_cnt != '0);
    assign rx_byte_block = st_q.ctl.rx_purge || (rx_cnt == CNT_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.ctl = ctl_t'(host_wdata[CTL_W-1:0]);
        end
        if (st_q.ctl.tx_purge) begin
            st_d.ovf = 1'b0;
        end else if (ovf_evt) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_overflow = st_q.ovf;

    pbf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st_q.ctl.tx_purge),
        .push      (tx_push),
        .push_data (host_wdata),
        .pop       (tx_byte_take && tx_byte_avail),
        .pop_data  (tx_byte),
        .count     (tx_cnt)
    );

    pbf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st_q.ctl.rx_purge),
        .push      (rx_byte_put && !rx_byte_block),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .pop_data  (rx_head),
        .count     (rx_cnt)
    );

    pbf_stat #(.IS_TX(1'b1), .CNT_W(CNT_W)) u_tx_stat (
        .count (tx_cnt),
        .purge (st_q.ctl.tx_purge),
        .pair  (st_q.ctl.tx_pair),
        .level (tx_level),
        .irq   (tx_irq)
    );

    pbf_stat #(.IS_TX(1'b0), .CNT_W(CNT_W)) u_rx_stat (
        .count (rx_cnt),
        .purge (st_q.ctl.rx_purge),
        .pair  (st_q.ctl.rx_pair),
        .level (rx_level),
        .irq   (rx_irq)
    );

endmodule

// File: rtl/pbf_ctl_chk.sv
module pbf_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic       host_we,
    input logic [1:0] host_addr,
    input logic       host_ready,
    input logic       tx_byte_avail,
    input logic       tx_byte_take,
    input logic       rx_byte_block,
    input logic [1:0] tx_level,
    input logic [1:0] rx_level,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic       tx_overflow,
    input logic [4:0] ctl_bits
);

    a_r2_level_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level != 2'b10) && (rx_level != 2'b10));

    a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_bits[3] && tx_level == 2'b01 && tx_byte_take && host_req && host_we
         && host_addr == 2'd1) |=> (tx_level == 2'b01));

    a_r5_tx_purge_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bits[3] |-> (tx_level == 2'b00 && !tx_byte_avail && !tx_irq));

    a_r6_rx_purge_block: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bits[4] |-> (rx_byte_block && rx_level == 2'b00 && !rx_irq));

    a_r9_rx_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && host_addr == 2'd2 && !ctl_bits[0]
         && rx_level == 2'b00) |-> !host_ready);

    a_r9_tx_write_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_addr == 2'd1 && !ctl_bits[0]
         && !ctl_bits[3] && tx_level == 2'b11) |-> !host_ready);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !ctl_bits[3]) |=> tx_overflow);

    a_r11_rx_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == 2'b11) |-> rx_byte_block);

endmodule

bind pbf_ctl pbf_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_req      (host_req),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .host_ready    (host_ready),
    .tx_byte_avail (tx_byte_avail),
    .tx_byte_take  (tx_byte_take),
    .rx_byte_block (rx_byte_block),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .tx_irq        (tx_irq),
    .rx_irq        (rx_irq),
    .tx_overflow   (tx_overflow),
    .ctl_bits      (ctl_bits)
);

// File: tb/tb_pbf_ctl.sv
`timescale 1ns/1ps
module tb_pbf_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0, host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic       tx_byte_avail;
    logic [7:0] tx_byte;
    logic       tx_byte_take = 1'b0;
    logic       rx_byte_put = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_byte_block;
    logic [1:0] tx_level, rx_level;
    logic       tx_irq, rx_irq, tx_overflow;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pbf_ctl #(.DATA_W(8)) dut (.*);

    typedef struct packed {
        logic [1:0] kind;   // 0 write, 1 read, 2 rx put, 3 tx take
        logic [1:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [1:0] etx;
        logic [1:0] erx;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd1, 8'hA1, 8'h00, 2'b01, 2'b00},
        '{2'd0, 2'd1, 8'hB2, 8'h00, 2'b11, 2'b00},
        '{2'd3, 2'd0, 8'h00, 8'hA1, 2'b01, 2'b00},
        '{2'd0, 2'd1, 8'hC3, 8'h00, 2'b11, 2'b00},
        '{2'd3, 2'd0, 8'h00, 8'hB2, 2'b01, 2'b00},
        '{2'd3, 2'd0, 8'h00, 8'hC3, 2'b00, 2'b00},
        '{2'd2, 2'd0, 8'h11, 8'h00, 2'b00, 2'b01},
        '{2'd2, 2'd0, 8'h22, 8'h00, 2'b00, 2'b11},
        '{2'd1, 2'd2, 8'h00, 8'h11, 2'b00, 2'b01},
        '{2'd2, 2'd0, 8'h33, 8'h00, 2'b00, 2'b11},
        '{2'd1, 2'd2, 8'h00, 8'h22, 2'b00, 2'b01},
        '{2'd1, 2'd2, 8'h00, 8'h33, 2'b00, 2'b00},
        '{2'd0, 2'd0, 8'h06, 8'h00, 2'b00, 2'b00},
        '{2'd1, 2'd0, 8'h00, 8'h06, 2'b00, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_op(input logic we, input logic [1:0] a, input logic [7:0] wd,
                           output logic [7:0] rd, output logic rdy);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        #1; rd = host_rdata; rdy = host_ready;
        @(posedge clk); #1;
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] rd; logic rdy;
        host_op(1'b1, a, d, rd, rdy);
    endtask

    task automatic rx_put(input logic [7:0] d, output logic blk);
        @(negedge clk);
        rx_byte_put = 1'b1; rx_byte = d;
        #1; blk = rx_byte_block;
        @(posedge clk); #1;
        rx_byte_put = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] d, output logic av);
        @(negedge clk);
        tx_byte_take = 1'b1;
        #1; d = tx_byte; av = tx_byte_avail;
        @(posedge clk); #1;
        tx_byte_take = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd, b;
        logic       rdy, blk, av;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 tx_level", tx_level, 2'b00);
        chk("R1 rx_level", rx_level, 2'b00);
        chk("R1 tx_irq", tx_irq, 1'b1);
        chk("R1 rx_irq", rx_irq, 1'b0);
        chk("R1 overflow", tx_overflow, 1'b0);
        chk("R1 avail", tx_byte_avail, 1'b0);
        chk("R1 block", rx_byte_block, 1'b0);
        host_op(1'b0, 2'd0, 8'h00, rd, rdy);
        chk("R1 ctl read", rd, 8'h00);

        // vector table: R2 R3 R4 R11 basic traffic
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                2'd0: begin
                    host_op(1'b1, VEC[i].addr, VEC[i].data, rd, rdy);
                    chk($sformatf("R4 vec%0d ready", i), rdy, 1'b1);
                end
                2'd1: begin
                    host_op(1'b0, VEC[i].addr, 8'h00, rd, rdy);
                    chk($sformatf("R3 vec%0d rdata", i), rd, VEC[i].exp);
                end
                2'd2: begin
                    rx_put(VEC[i].data, blk);
                    chk($sformatf("R11 vec%0d block", i), blk, 1'b0);
                end
                default: begin
                    tx_take(b, av);
                    chk($sformatf("R11 vec%0d tx_byte", i), b, VEC[i].exp);
                end
            endcase
            chk($sformatf("R2 vec%0d tx_level", i), tx_level, VEC[i].etx);
            chk($sformatf("R2 vec%0d rx_level", i), rx_level, VEC[i].erx);
        end
        wr(2'd0, 8'h00);

        // R7 transmit threshold
        chk("R7 empty irq", tx_irq, 1'b1);
        wr(2'd1, 8'h01);
        chk("R7 one held irq", tx_irq, 1'b1);
        wr(2'd1, 8'h02);
        chk("R7 full irq", tx_irq, 1'b0);
        wr(2'd0, 8'h02);
        chk("R7 pair full irq", tx_irq, 1'b0);
        tx_take(b, av);
        chk("R7 pair one free irq", tx_irq, 1'b0);
        tx_take(b, av);
        chk("R7 pair empty irq", tx_irq, 1'b1);
        wr(2'd0, 8'h00);

        // R8 receive threshold
        rx_put(8'h91, blk);
        chk("R8 one byte irq", rx_irq, 1'b1);
        wr(2'd0, 8'h04);
        chk("R8 pair one byte irq", rx_irq, 1'b0);
        rx_put(8'h92, blk);
        chk("R8 pair two bytes irq", rx_irq, 1'b1);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R8 drained level", rx_level, 2'b00);
        wr(2'd0, 8'h00);

        // R9 stalling accesses
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R9 empty read ready", rdy, 1'b0);
        chk("R9 empty read level", rx_level, 2'b00);
        wr(2'd1, 8'h61);
        wr(2'd1, 8'h62);
        host_op(1'b1, 2'd1, 8'h63, rd, rdy);
        chk("R9 full write ready", rdy, 1'b0);
        chk("R9 no overflow", tx_overflow, 1'b0);
        tx_take(b, av);
        chk("R9 first byte", b, 8'h61);
        tx_take(b, av);
        chk("R9 second byte", b, 8'h62);
        chk("R9 stalled byte not stored", tx_level, 2'b00);

        // R10 non-stalling accesses
        wr(2'd0, 8'h01);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R10 empty read ready", rdy, 1'b1);
        chk("R10 empty read data", rd, 8'h00);
        chk("R10 empty read level", rx_level, 2'b00);
        wr(2'd1, 8'h51);
        wr(2'd1, 8'h52);
        host_op(1'b1, 2'd1, 8'h99, rd, rdy);
        chk("R10 full write ready", rdy, 1'b1);
        chk("R10 overflow set", tx_overflow, 1'b1);
        chk("R10 full level", tx_level, 2'b11);
        tx_take(b, av);
        chk("R10 byte one", b, 8'h51);
        tx_take(b, av);
        chk("R10 byte two", b, 8'h52);
        chk("R10 dropped byte absent", tx_byte_avail, 1'b0);
        chk("R10 overflow held", tx_overflow, 1'b1);
        wr(2'd0, 8'h09);
        @(posedge clk); #1;
        chk("R10 overflow cleared by purge", tx_overflow, 1'b0);
        wr(2'd0, 8'h00);

        // R5 transmit purge
        wr(2'd1, 8'hD1);
        wr(2'd0, 8'h08);
        chk("R5 level", tx_level, 2'b00);
        chk("R5 avail", tx_byte_avail, 1'b0);
        chk("R5 irq", tx_irq, 1'b0);
        host_op(1'b1, 2'd1, 8'hD2, rd, rdy);
        chk("R5 write ready", rdy, 1'b1);
        chk("R5 write discarded", tx_level, 2'b00);
        wr(2'd0, 8'h00);
        chk("R5 after clear level", tx_level, 2'b00);
        chk("R5 after clear avail", tx_byte_avail, 1'b0);
        chk("R5 after clear irq", tx_irq, 1'b1);

        // R6 receive purge
        rx_put(8'hE1, blk);
        rx_put(8'hE2, blk);
        wr(2'd0, 8'h10);
        chk("R6 level", rx_level, 2'b00);
        chk("R6 block", rx_byte_block, 1'b1);
        chk("R6 irq", rx_irq, 1'b0);
        rx_put(8'h77, blk);
        chk("R6 put refused", blk, 1'b1);
        chk("R6 level after put", rx_level, 2'b00);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R6 read stalls", rdy, 1'b0);
        wr(2'd0, 8'h00);
        chk("R6 after clear level", rx_level, 2'b00);
        chk("R6 after clear block", rx_byte_block, 1'b0);
        rx_put(8'h44, blk);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R6 old bytes gone", rd, 8'h44);

        // R3 simultaneous push and pop
        wr(2'd1, 8'h71);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 2'd1; host_wdata = 8'h72;
        tx_byte_take = 1'b1;
        #1; b = tx_byte; rdy = host_ready;
        @(posedge clk); #1;
        host_req = 1'b0; host_we = 1'b0; tx_byte_take = 1'b0;
        chk("R3 popped head", b, 8'h71);
        chk("R3 push ready", rdy, 1'b1);
        chk("R3 level held", tx_level, 2'b01);
        tx_take(b, av);
        chk("R3 pushed byte next", b, 8'h72);
        chk("R3 empty after", tx_level, 2'b00);

        // R11 put into full receive FIFO
        rx_put(8'h81, blk);
        rx_put(8'h82, blk);
        rx_put(8'h83, blk);
        chk("R11 full block", blk, 1'b1);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R11 first", rd, 8'h81);
        host_op(1'b0, 2'd2, 8'h00, rd, rdy);
        chk("R11 second", rd, 8'h82);
        chk("R11 extra dropped", rx_level, 2'b00);

        finish_run();
    end

endmodule